// File: doc/BRIEF.md
# Three-Lane Balanced-Code Frame Deserializer

This block turns three sampled serial lanes into one 21-bit parallel word per frame. It runs on a bit-rate clock that is nine times the frame rate, so each rising edge delivers one bit per lane. A fourth sampled lane carries the parallel-rate clock waveform. The block finds frame boundaries on that lane by looking for its low-to-high transitions.

Every lane frame is nine bits long: seven payload bits and two complementary marker bits. The transmitter inverts a frame's payload when that keeps its line code balanced, and it uses the marker pair to record that choice. The block collects each frame and reads the marker pair. It restores the payload to its true polarity and places the three 7-bit pieces side by side in the output word. A marker pair whose two bits are equal is a coding fault. Each lane has its own sticky fault flag that records such a pair.

The block sits directly behind a front end that has already recovered the bit clock and sampled the lanes. Downstream logic takes the word on the cycle its valid strobe is high.

Top module: `dcbd_deser_top`

## Requirements
- R1: The decoded payload of lane 0 drives word bits 6..0, lane 1 drives bits 13..7 and lane 2 drives bits 20..14, with payload bit n of a lane on word bit 7*lane+n.
- R2: Within a frame the nine samples of a lane, in arrival order (slot 0 to slot 8), are: payload bits 2, 3, 4, marker A, payload bits 5, 6, marker B, payload bits 0, 1.
- R3: Markers A=1, B=0 mean the payload was sent inverted and is inverted back before output. Markers A=0, B=1 mean it is passed unchanged.
- R4: When markers A and B are equal (both 0 or both 1), the lane's payload is passed unchanged and the lane's bit of the fault output (bit index = lane number) is set.
- R5: A fault bit stays set through later good frames until reset. Faults on one lane do not touch the other lanes' bits.
- R6: Slot 0 of a frame is the sample at which the clock lane reads 1 after reading 0 on the previous sample. A frame decodes correctly whether the clock lane stays high for 4 or for 5 of its 9 slots.
- R7: A word is produced only when the eight samples following a slot-0 sample contain no new 0-to-1 transition of the clock lane. A new transition restarts the frame. If the clock lane stops toggling, no further word is produced.
- R8: The word and the valid strobe are registered together and become visible one clock after the slot-8 sample. Valid is high for exactly one clock per frame, and the word holds its value between strobes.
- R9: An active-low reset clears the word, the valid strobe and all fault bits at once. Its release takes effect after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, one sample per lane per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ck_lane_i | input | 1 | Sampled parallel-rate clock lane |
| ser_i | input | 3 | Sampled serial data lanes, bit n is lane n |
| word_o | output | 21 | Decoded parallel word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| code_err_o | output | 3 | Sticky per-lane marker fault flags |

## Verification
The only delayed result is the word with its strobe. It is due one clock after the edge that samples slot 8 of a lane frame. The bench therefore drives each slot at a falling edge and checks the word, strobe and fault flags at the falling edge that follows the slot-8 capture. In the middle of every frame it checks again that the strobe is low and the previous word is still held. The reset clear is asynchronous, so it is checked one time step after the reset input falls. Aborted frames and a stalled clock lane are checked at every sample: the strobe must stay low throughout.

// File: rtl/dcbd_pkg.sv
package dcbd_pkg;

  // Frame geometry: seven payload bits and two marker bits per lane frame.
  localparam int unsigned PAY_W      = 7;
  localparam int unsigned SLOTS      = PAY_W + 2;
  localparam int unsigned SLOT_W     = $clog2(SLOTS + 1);
  localparam int unsigned SLOT_MRK_A = 3;
  localparam int unsigned SLOT_MRK_B = 6;
  // Counter value meaning "not inside a frame".
  localparam logic [SLOT_W-1:0] SLOT_IDLE = SLOT_W'(SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  // Serial position of payload bit b inside the nine-slot frame.
  function automatic int unsigned pay_slot(input int unsigned b);
    if (b >= 5)      return b - 1;
    else if (b >= 2) return b - 2;
    else             return b + 7;
  endfunction

endpackage

// File: rtl/dcbd_rst_sync.sv
module dcbd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/dcbd_frame_align.sv
module dcbd_frame_align
  import dcbd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_lane_i,
  output logic frm_done_o
);

  logic              ck_prev_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_cur;
  logic              rise;

  always_comb begin
    rise = ck_lane_i & ~ck_prev_q;
    if (rise)                   slot_cur = '0;
    else if (slot_q < SLOT_LAST) slot_cur = slot_q + SLOT_W'(1);
    else                        slot_cur = SLOT_IDLE;
    frm_done_o = (slot_cur == SLOT_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_prev_q <= 1'b0;
      slot_q    <= SLOT_IDLE;
    end else begin
      ck_prev_q <= ck_lane_i;
      slot_q    <= slot_cur;
    end
  end

  // R6/R7: a clock-lane rise starts a frame, so it cannot complete on the next sample.
  a_r7_rise_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_lane_i && !ck_prev_q) |=> !frm_done_o);

endmodule

// File: rtl/dcbd_lane_dec.sv
module dcbd_lane_dec
  import dcbd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             frm_done_i,
  output logic [PAY_W-1:0] pay_o,
  output logic             err_o
);

  logic [SLOTS-2:0] sr_q;
  logic [SLOTS-2:0] sr_d;
  logic [SLOTS-1:0] frm;
  logic [PAY_W-1:0] raw;
  logic             mrk_a;
  logic             mrk_b;
  logic             flip;
  logic             bad;
  logic             err_q;
  logic             err_d;

  always_comb begin
    sr_d  = {ser_i, sr_q[SLOTS-2:1]};
    frm   = {ser_i, sr_q};
    mrk_a = frm[SLOT_MRK_A];
    mrk_b = frm[SLOT_MRK_B];
    flip  = mrk_a & ~mrk_b;
    bad   = ~(mrk_a ^ mrk_b);
    for (int unsigned b = 0; b < PAY_W; b++) begin
      raw[b] = frm[pay_slot(b)];
    end
    pay_o = flip ? ~raw : raw;
    err_d = err_q | (frm_done_i & bad);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      if (frm_done_i) err_q <= err_d;
    end
  end

  assign err_o = err_q;

  // R5: the fault flag only moves at a frame boundary.
  a_r5_err_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_done_i |=> $stable(err_o));

endmodule

// File: rtl/dcbd_deser_top.sv
module dcbd_deser_top
  import dcbd_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ck_lane_i,
  input  logic [LANES-1:0]       ser_i,
  output logic [LANES*PAY_W-1:0] word_o,
  output logic                   word_vld_o,
  output logic [LANES-1:0]       code_err_o
);

  localparam int unsigned WORD_W = LANES * PAY_W;

  logic              rst_s_n;
  logic              frm_done;
  logic [WORD_W-1:0] word_cur;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              vld_q;
  logic              vld_d;

  dcbd_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s_n)
  );

  dcbd_frame_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_s_n),
    .ck_lane_i  (ck_lane_i),
    .frm_done_o (frm_done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dcbd_lane_dec u_dec (
      .clk_i      (clk_i),
      .rst_ni     (rst_s_n),
      .ser_i      (ser_i[l]),
      .frm_done_i (frm_done),
      .pay_o      (word_cur[l*PAY_W +: PAY_W]),
      .err_o      (code_err_o[l])
    );
  end

  always_comb begin
    word_d = frm_done ? word_cur : word_q;
    vld_d  = frm_done;
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  // R8: the strobe never lasts two cycles.
  a_r8_vld_single: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    word_vld_o |=> !word_vld_o);

  // R8: the word only changes together with its strobe.
  a_r8_word_hold: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !$stable(word_o) |-> word_vld_o);

  // R7: a strobe follows a completed frame from the aligner.
  a_r7_vld_after_frame: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    word_vld_o |-> $past(frm_done));

  // R5: fault bits never clear while out of reset.
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    ((code_err_o & $past(code_err_o)) == $past(code_err_o)));

endmodule

// File: tb/dcbd_deser_top_tb_top.sv
module dcbd_deser_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        ck_lane;
  logic [2:0]  ser;
  logic [20:0] word;
  logic        vld;
  logic [2:0]  err;

  int n_chk;
  int n_bad;
  logic [20:0] prev_word;
  logic [2:0]  exp_err;
  bit          finished;

  dcbd_deser_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ck_lane_i  (ck_lane),
    .ser_i      (ser),
    .word_o     (word),
    .word_vld_o (vld),
    .code_err_o (err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic slot_bit(input logic [6:0] tx, input logic [1:0] mk, input int k);
    case (k)
      0: return tx[2];
      1: return tx[3];
      2: return tx[4];
      3: return mk[1];
      4: return tx[5];
      5: return tx[6];
      6: return mk[0];
      7: return tx[0];
      default: return tx[1];
    endcase
  endfunction

  // p[l] is the true payload of lane l, mk[l] = {marker A, marker B}.
  task automatic send_frame(input logic [2:0][6:0] p, input logic [2:0][1:0] mk, input int hi, input string tag);
    logic [2:0][6:0] tx;
    for (int l = 0; l < 3; l++) tx[l] = (mk[l] == 2'b10) ? ~p[l] : p[l];
    for (int k = 0; k < 9; k++) begin
      ck_lane = (k < hi);
      for (int l = 0; l < 3; l++) ser[l] = slot_bit(tx[l], mk[l], k);
      @(negedge clk);
      if (k == 3) begin
        chk(vld == 1'b0, "R8 strobe low mid-frame", 32'(vld), 0);
        chk(word == prev_word, "R8 word held mid-frame", 32'(word), 32'(prev_word));
      end
    end
    for (int l = 0; l < 3; l++) if (mk[l] == 2'b11 || mk[l] == 2'b00) exp_err[l] = 1'b1;
    chk(vld == 1'b1, {tag, " R8 strobe after slot 8"}, 32'(vld), 1);
    chk(word == 21'(p), {tag, " word"}, 32'(word), 32'(21'(p)));
    chk(err == exp_err, {tag, " R4 R5 fault flags"}, 32'(err), 32'(exp_err));
    prev_word = 21'(p);
  endtask

  task automatic idle(input int n, input string tag);
    ck_lane = 1'b0;
    ser = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(vld == 1'b0 && word == prev_word, tag, {10'd0, vld, word}, {11'd0, prev_word});
    end
  endtask

  // Starts a frame but restarts it with a new rise after n slots.
  task automatic partial(input int n);
    for (int k = 0; k < n; k++) begin
      ck_lane = (k < 3);
      ser = 3'b101;
      @(negedge clk);
      chk(vld == 1'b0, "R7 no strobe for aborted frame", 32'(vld), 0);
    end
  endtask

  task automatic t_reset_state;
    chk(word == 0, "R9 reset word", 32'(word), 0);
    chk(vld == 0, "R9 reset strobe", 32'(vld), 0);
    chk(err == 0, "R9 reset faults", 32'(err), 0);
  endtask

  task automatic t_plain;
    send_frame({7'h55, 7'h2A, 7'h01}, {2'b01, 2'b01, 2'b01}, 4, "R1 R2 plain");
    send_frame({7'h40, 7'h00, 7'h7F}, {2'b01, 2'b01, 2'b01}, 5, "R1 R6 plain duty5");
    send_frame({7'h12, 7'h34, 7'h56}, {2'b01, 2'b01, 2'b01}, 4, "R2 plain duty4");
  endtask

  task automatic t_invert;
    send_frame({7'h0F, 7'h70, 7'h33}, {2'b10, 2'b10, 2'b10}, 5, "R3 all inverted");
    send_frame({7'h01, 7'h7E, 7'h5A}, {2'b10, 2'b01, 2'b10}, 4, "R3 mixed");
  endtask

  task automatic t_faults;
    send_frame({7'h11, 7'h22, 7'h33}, {2'b01, 2'b11, 2'b01}, 4, "R4 lane1 both high");
    send_frame({7'h44, 7'h55, 7'h66}, {2'b01, 2'b01, 2'b01}, 5, "R5 sticky after good");
    send_frame({7'h07, 7'h08, 7'h09}, {2'b00, 2'b01, 2'b10}, 4, "R4 lane2 both low");
  endtask

  task automatic t_realign;
    partial(5);
    send_frame({7'h3C, 7'h4B, 7'h5A}, {2'b01, 2'b10, 2'b01}, 4, "R7 after restart");
    idle(20, "R7 stalled clock lane no word");
  endtask

  task automatic t_mid_reset;
    rst_n = 1'b0;
    #1;
    t_reset_state();
    exp_err = '0;
    prev_word = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R9 idle after reset");
    send_frame({7'h61, 7'h62, 7'h63}, {2'b01, 2'b01, 2'b10}, 5, "R9 frame after reset");
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    prev_word = '0;
    exp_err = '0;
    finished = 0;
    rst_n = 1'b0;
    ck_lane = 1'b0;
    ser = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    idle(4, "R9 idle after release");
    t_plain();
    t_invert();
    t_faults();
    t_realign();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule